// File: doc/BRIEF.md
# Predicated Execution Condition Unit

This block decides, for every instruction issued to it, whether that instruction may commit. It keeps four status flags: negative, zero, carry and signed overflow. It checks each instruction's 4-bit condition code against those flags. The result is an execute enable and a writeback enable. Flag updates coming from the arithmetic unit are accepted only from instructions that actually execute. Compare-type operations update the flags but never write a register.

The block also runs an if-then window. An if-then instruction names a base condition, a length of one to four, and a then/else pattern. The instructions that follow it are then predicated by that window and not by their own condition fields. Each slot uses either the base condition or its inverse. The window moves forward by one slot each time an instruction is issued, and the program counter plays no part in it. A synchronous reset clears the flags and ends any open window.

Top module: `pred_cond_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four flags to zero and leaves no if-then window open.
- R2: Outside an if-then window, an issued instruction executes when its condition code passes. The code is bits 31..28 of the instruction word. The flags are N=flags[3], Z=flags[2], C=flags[1], V=flags[0]. Code 0 passes if Z is set and 1 if Z is clear. Code 2 passes if C is set and 3 if C is clear. Code 4 passes if N is set and 5 if N is clear. Code 6 passes if V is set and 7 if V is clear. Code 8 passes if C is set and Z is clear; code 9 is its inverse. Code 10 passes if N equals V and 11 if N differs from V. Code 12 passes if Z is clear and N equals V; code 13 is its inverse. Codes 14 and 15 always pass.
- R3: An executing instruction with `set_flags` loads `alu_flags` into the flags, visible from the next cycle. An instruction that does not set flags leaves them unchanged.
- R4: An executing compare (`is_cmp`) loads `alu_flags` into the flags even without `set_flags`, and it never raises `wb_en`.
- R5: An issued instruction whose condition fails has `exec_en` and `wb_en` low and leaves the flags unchanged, even when it requests a flag update.
- R6: An issued if-then instruction (`is_it`) always executes. Its own condition field is the base condition. It opens a window of `it_len` slots: 0 opens none, 1 to 4 opens that many, and larger values are treated as 4. While the window is open, `it_active` is high and the instruction's own condition field is ignored.
- R7: Slot k of the window (k=0 first) uses `it_te[k]`. A value of 1 selects the base condition. A value of 0 selects its inverse, which is the base code with bit 0 flipped; for base codes 14 and 15 the inverse still always passes.
- R8: The window advances by one slot for every issued non-if-then instruction, whether or not that instruction passes. Cycles with no issue leave the window unchanged. The window closes after its last slot.
- R9: An if-then instruction issued while a window is open replaces the remaining window with the new one.
- R10: `wb_en` is high only for an executing instruction that has a destination (`has_dest`) and is neither a compare nor an if-then instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction is issued this cycle |
| instr_cond | input | 4 | Condition field, bits 31..28 of the instruction word |
| is_it | input | 1 | The issued instruction is an if-then setup |
| it_te | input | 4 | Then/else bit per slot, slot 0 in bit 0 |
| it_len | input | 3 | Number of predicated slots |
| set_flags | input | 1 | The instruction requests a flag update |
| is_cmp | input | 1 | Compare-type operation: flags only, no register result |
| has_dest | input | 1 | The instruction names a destination register |
| alu_flags | input | 4 | Flags produced by the arithmetic unit {N,Z,C,V} |
| exec_en | output | 1 | The issued instruction may commit |
| wb_en | output | 1 | Result writeback allowed |
| flags | output | 4 | Current flags {N,Z,C,V} |
| it_active | output | 1 | An if-then window is open |

## Verification
The assertions assume that `is_it` and `is_cmp` are never high together. They also assume that control inputs are only meaningful while `issue_valid` is high, and that `alu_flags` is stable throughout the issuing cycle. The stimulus keeps to these assumptions. Each instruction is driven at the falling edge and held for one full cycle. Between instructions the bench drops `issue_valid` and never sets both opcode-type strobes at once. Idle cycles are placed inside if-then windows on purpose, to show that only issued instructions advance the window.

// File: rtl/pred_pkg.sv
package pred_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [3:0] {
    CC_EQ  = 4'd0,
    CC_NE  = 4'd1,
    CC_CS  = 4'd2,
    CC_CC  = 4'd3,
    CC_MI  = 4'd4,
    CC_PL  = 4'd5,
    CC_VS  = 4'd6,
    CC_VC  = 4'd7,
    CC_HI  = 4'd8,
    CC_LS  = 4'd9,
    CC_GE  = 4'd10,
    CC_LT  = 4'd11,
    CC_GT  = 4'd12,
    CC_LE  = 4'd13,
    CC_AL  = 4'd14,
    CC_RSV = 4'd15
  } cond_e;

  // Evaluate one condition code against the flags.
  function automatic logic cond_holds(cond_e code, flags_t f);
    logic r;
    case (code)
      CC_EQ:   r = f.z;
      CC_NE:   r = !f.z;
      CC_CS:   r = f.c;
      CC_CC:   r = !f.c;
      CC_MI:   r = f.n;
      CC_PL:   r = !f.n;
      CC_VS:   r = f.v;
      CC_VC:   r = !f.v;
      CC_HI:   r = f.c && !f.z;
      CC_LS:   r = !f.c || f.z;
      CC_GE:   r = (f.n == f.v);
      CC_LT:   r = (f.n != f.v);
      CC_GT:   r = !f.z && (f.n == f.v);
      CC_LE:   r = f.z || (f.n != f.v);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  // Complementary condition; the always-codes stay always.
  function automatic cond_e cond_invert(cond_e code);
    if (code == CC_AL || code == CC_RSV) return code;
    return cond_e'(code ^ 4'd1);
  endfunction

endpackage

// File: rtl/pred_flag_reg.sv
module pred_flag_reg
  import pred_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr,
  input  flags_t wr_flags,
  output flags_t q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (wr)  q <= wr_flags;
  end

endmodule

// File: rtl/pred_it_seq.sv
module pred_it_seq
  import pred_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LW    = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  cond_e            load_base,
  input  logic [SLOTS-1:0] load_te,
  input  logic [LW-1:0]    load_len,
  input  logic             retire,
  output logic             active,
  output logic             then_bit,
  output cond_e            base,
  output logic [LW-1:0]    left
);

  localparam logic [LW-1:0] MAXLEN = LW'(SLOTS);

  logic [SLOTS-1:0] te_q;
  logic [LW-1:0]    cnt_q;
  cond_e            base_q;
  logic [LW-1:0]    len_clamped;

  assign len_clamped = (load_len > MAXLEN) ? MAXLEN : load_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      te_q   <= '0;
      cnt_q  <= '0;
      base_q <= CC_AL;
    end else if (load) begin
      te_q   <= load_te;
      cnt_q  <= len_clamped;
      base_q <= load_base;
    end else if (retire && cnt_q != '0) begin
      te_q   <= te_q >> 1;
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign active   = (cnt_q != '0);
  assign then_bit = te_q[0];
  assign base     = base_q;
  assign left     = cnt_q;

endmodule

// File: rtl/pred_cond_sel.sv
module pred_cond_sel
  import pred_pkg::*;
(
  input  cond_e  instr_code,
  input  logic   in_window,
  input  logic   then_bit,
  input  cond_e  window_base,
  input  flags_t cur_flags,
  output cond_e  eff_code,
  output logic   pass
);

  always_comb begin
    if (in_window)
      eff_code = then_bit ? window_base : cond_invert(window_base);
    else
      eff_code = instr_code;
    pass = cond_holds(eff_code, cur_flags);
  end

endmodule

// File: rtl/pred_cond_unit.sv
module pred_cond_unit
  import pred_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LW    = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic [3:0]       instr_cond,
  input  logic             is_it,
  input  logic [SLOTS-1:0] it_te,
  input  logic [LW-1:0]    it_len,
  input  logic             set_flags,
  input  logic             is_cmp,
  input  logic             has_dest,
  input  logic [3:0]       alu_flags,
  output logic             exec_en,
  output logic             wb_en,
  output logic [3:0]       flags,
  output logic             it_active
);

  flags_t        flags_q;
  cond_e         it_base;
  cond_e         eff_code;
  logic          slot_then;
  logic [LW-1:0] it_left;
  logic          cond_ok;
  logic          flag_wr;
  logic          it_load;
  logic          slot_retire;

  assign it_load     = issue_valid && is_it;
  assign slot_retire = issue_valid && !is_it;

  pred_it_seq #(.SLOTS(SLOTS), .LW(LW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (it_load),
    .load_base (cond_e'(instr_cond)),
    .load_te   (it_te),
    .load_len  (it_len),
    .retire    (slot_retire),
    .active    (it_active),
    .then_bit  (slot_then),
    .base      (it_base),
    .left      (it_left)
  );

  pred_cond_sel u_sel (
    .instr_code  (cond_e'(instr_cond)),
    .in_window   (it_active),
    .then_bit    (slot_then),
    .window_base (it_base),
    .cur_flags   (flags_q),
    .eff_code    (eff_code),
    .pass        (cond_ok)
  );

  assign exec_en = issue_valid && (is_it || cond_ok);
  assign flag_wr = slot_retire && cond_ok && (set_flags || is_cmp);
  assign wb_en   = exec_en && !is_it && !is_cmp && has_dest;

  pred_flag_reg u_flags (
    .clk      (clk),
    .rst      (rst),
    .wr       (flag_wr),
    .wr_flags (flags_t'(alu_flags)),
    .q        (flags_q)
  );

  assign flags = flags_q;

endmodule

// File: rtl/pred_cond_unit_chk.sv
module pred_cond_unit_chk #(
  parameter int SLOTS = 4,
  parameter int LW    = $clog2(SLOTS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_valid,
  input logic          is_it,
  input logic          is_cmp,
  input logic [3:0]    alu_flags,
  input logic          exec_en,
  input logic          wb_en,
  input logic [3:0]    flags,
  input logic          it_active,
  input logic          cond_ok,
  input logic          flag_wr,
  input logic [LW-1:0] it_left
);

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) if (rst) rst_seen <= 1'b1;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (rst_seen && $past(rst)) |-> (flags == 4'd0 && !it_active)); // R1

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> (flags == $past(alu_flags))); // R3

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_wr |=> $stable(flags)); // R3

  AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (rst)
    is_cmp |-> !wb_en); // R4

  AST_FAIL_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !is_it && !cond_ok) |=> $stable(flags)); // R5

  AST_FAIL_NO_EXEC: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !is_it && !cond_ok) |-> (!exec_en && !wb_en)); // R5

  AST_IT_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && is_it) |-> (exec_en && !wb_en)); // R6

  AST_IT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> (it_active == $past(it_active))); // R8

  AST_IT_LAST_SLOT: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !is_it && it_left == LW'(1)) |=> !it_active); // R8

  AST_WB_NEEDS_EXEC: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> exec_en); // R10

endmodule

bind pred_cond_unit pred_cond_unit_chk #(.SLOTS(SLOTS), .LW(LW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .is_it       (is_it),
  .is_cmp      (is_cmp),
  .alu_flags   (alu_flags),
  .exec_en     (exec_en),
  .wb_en       (wb_en),
  .flags       (flags),
  .it_active   (it_active),
  .cond_ok     (cond_ok),
  .flag_wr     (flag_wr),
  .it_left     (it_left)
);

// File: tb/sim_pred_cond_unit.sv
module sim_pred_cond_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue_valid = 1'b0;
  logic [3:0] instr_cond = 4'd0;
  logic       is_it = 1'b0;
  logic [3:0] it_te = 4'd0;
  logic [2:0] it_len = 3'd0;
  logic       set_flags = 1'b0;
  logic       is_cmp = 1'b0;
  logic       has_dest = 1'b0;
  logic [3:0] alu_flags = 4'd0;
  logic       exec_en, wb_en, it_active;
  logic [3:0] flags;

  int n_checks = 0;
  int n_fail   = 0;
  logic got_exec, got_wb;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pred_cond_unit u0 (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr_cond(instr_cond),
    .is_it(is_it), .it_te(it_te), .it_len(it_len), .set_flags(set_flags),
    .is_cmp(is_cmp), .has_dest(has_dest), .alu_flags(alu_flags),
    .exec_en(exec_en), .wb_en(wb_en), .flags(flags), .it_active(it_active)
  );

  // Independent model: pairs of codes share a test, odd member inverts it.
  function automatic logic model_pass(logic [3:0] code, logic [3:0] f);
    logic n, z, c, v, base;
    {n, z, c, v} = f;
    if (code >= 4'd14) return 1'b1;
    unique case (code[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = ~(n ^ v);
      default: base = ~z & ~(n ^ v);
    endcase
    return code[0] ? ~base : base;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue one instruction; starts and ends at a falling edge.
  task automatic issue(input logic [31:0] word, input logic it, input logic [3:0] te,
                       input logic [2:0] len, input logic sf, input logic cmp,
                       input logic dst, input logic [3:0] af);
    issue_valid = 1'b1;
    instr_cond  = word[31:28];
    is_it = it; it_te = te; it_len = len;
    set_flags = sf; is_cmp = cmp; has_dest = dst; alu_flags = af;
    #2;
    got_exec = exec_en;
    got_wb   = wb_en;
    @(posedge clk); #1;
    issue_valid = 1'b0; is_it = 1'b0; set_flags = 1'b0; is_cmp = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic load_flags(input logic [3:0] f);
    issue({4'd14, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b1, 1'b0, 1'b0, f);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(flags == 4'd0, "R1 flags after reset", flags, 0);
    check(!it_active, "R1 window after reset", it_active, 0);
    load_flags(4'b1111);
    issue({4'd0, 28'd0}, 1'b1, 4'b1111, 3'd4, 1'b0, 1'b0, 1'b0, 4'd0);
    do_reset();
    check(flags == 4'd0, "R1 flags cleared mid-run", flags, 0);
    check(!it_active, "R1 window cleared mid-run", it_active, 0);
  endtask

  task automatic t_table();
    for (int f = 0; f < 16; f++) begin
      load_flags(f[3:0]);
      for (int c = 0; c < 16; c++) begin
        issue({c[3:0], 28'h0ABCDEF}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd0);
        check(got_exec == model_pass(c[3:0], f[3:0]), $sformatf("R2 code %0d flags %0d", c, f),
              got_exec, model_pass(c[3:0], f[3:0]));
      end
    end
  endtask

  task automatic t_flags();
    load_flags(4'b1010);
    check(flags == 4'b1010, "R3 flag load", flags, 4'b1010);
    issue({4'd14, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'b0101);
    check(flags == 4'b1010, "R3 no-set keeps flags", flags, 4'b1010);
  endtask

  task automatic t_cmp();
    issue({4'd14, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b1, 1'b1, 4'b0100);
    check(got_exec == 1'b1, "R4 compare executes", got_exec, 1);
    check(got_wb == 1'b0, "R4 compare no writeback", got_wb, 0);
    check(flags == 4'b0100, "R4 compare sets flags", flags, 4'b0100);
  endtask

  task automatic t_fail();
    load_flags(4'b0100);
    issue({4'd1, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b1, 1'b0, 1'b1, 4'b1111);
    check(got_exec == 1'b0, "R5 failed exec", got_exec, 0);
    check(got_wb == 1'b0, "R5 failed writeback", got_wb, 0);
    check(flags == 4'b0100, "R5 failed keeps flags", flags, 4'b0100);
    issue({4'd1, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b1, 1'b0, 4'b0000);
    check(flags == 4'b0100, "R5 failed compare keeps flags", flags, 4'b0100);
  endtask

  task automatic t_window();
    load_flags(4'b0100);
    issue({4'd0, 28'd0}, 1'b1, 4'b0101, 3'd4, 1'b0, 1'b0, 1'b1, 4'd0);
    check(got_exec == 1'b1 && got_wb == 1'b0, "R6 if-then executes, no writeback",
          {got_exec, got_wb}, 2);
    check(it_active == 1'b1, "R6 window open", it_active, 1);
    issue({4'd1, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd0);
    check(got_exec == 1'b1, "R7 slot0 then (own code ignored)", got_exec, 1);
    issue({4'd0, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd0);
    check(got_exec == 1'b0, "R7 slot1 else", got_exec, 0);
    idle(); idle();
    check(it_active == 1'b1, "R8 idle keeps window", it_active, 1);
    issue({4'd1, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd0);
    check(got_exec == 1'b1, "R8 slot2 after idle", got_exec, 1);
    issue({4'd14, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd0);
    check(got_exec == 1'b0, "R7 slot3 else overrides always", got_exec, 0);
    check(it_active == 1'b0, "R8 window closes", it_active, 0);
    issue({4'd1, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd0);
    check(got_exec == 1'b0, "R6 own code after window", got_exec, 0);
  endtask

  task automatic t_len();
    issue({4'd0, 28'd0}, 1'b1, 4'b1111, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0);
    check(it_active == 1'b0, "R6 length 0 opens none", it_active, 0);
    issue({4'd0, 28'd0}, 1'b1, 4'b1111, 3'd2, 1'b0, 1'b0, 1'b0, 4'd0);
    issue({4'd14, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0);
    check(it_active == 1'b1, "R6 length 2 after one", it_active, 1);
    issue({4'd14, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0);
    check(it_active == 1'b0, "R6 length 2 after two", it_active, 0);
    issue({4'd0, 28'd0}, 1'b1, 4'b1111, 3'd7, 1'b0, 1'b0, 1'b0, 4'd0);
    for (int k = 0; k < 3; k++)
      issue({4'd14, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0);
    check(it_active == 1'b1, "R6 clamp still open after 3", it_active, 1);
    issue({4'd14, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0);
    check(it_active == 1'b0, "R6 clamp closes after 4", it_active, 0);
  endtask

  task automatic t_replace();
    load_flags(4'b0100);
    issue({4'd0, 28'd0}, 1'b1, 4'b1111, 3'd4, 1'b0, 1'b0, 1'b0, 4'd0);
    issue({4'd14, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd0);
    issue({4'd1, 28'd0}, 1'b1, 4'b0001, 3'd1, 1'b0, 1'b0, 1'b0, 4'd0);
    issue({4'd0, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd0);
    check(got_exec == 1'b0, "R9 new base applies", got_exec, 0);
    check(it_active == 1'b0, "R9 new length applies", it_active, 0);
    issue({4'd14, 28'd0}, 1'b1, 4'b0000, 3'd1, 1'b0, 1'b0, 1'b0, 4'd0);
    issue({4'd0, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b1, 1'b0, 1'b1, 4'b0010);
    check(got_exec == 1'b1, "R7 else of always passes", got_exec, 1);
    check(flags == 4'b0010, "R3 slot sets flags", flags, 4'b0010);
  endtask

  task automatic t_wb();
    issue({4'd14, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0);
    check(got_exec == 1'b1 && got_wb == 1'b0, "R10 no dest no writeback", {got_exec, got_wb}, 2);
    issue({4'd14, 28'd0}, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd0);
    check(got_wb == 1'b1, "R10 dest writes back", got_wb, 1);
    issue({4'd14, 28'd0}, 1'b1, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd0);
    check(got_wb == 1'b0, "R10 if-then no writeback", got_wb, 0);
  endtask

  initial begin
    t_reset();
    t_table();
    t_flags();
    t_cmp();
    t_fail();
    t_window();
    t_len();
    t_replace();
    t_wb();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule